// File: doc/BRIEF.md
# Delay Calibration Controller with Period Measurement

This controller performs a one-time timing calibration each time it leaves reset or receives a recalibration request. A time-to-digital converter outside the block compares one clock period against a delay chain whose speed depends on the supply voltage. It delivers the result as a thermometer word. The controller reduces that word to a stage count and uses the count for two settings:

- A programmable lookup gives the step code for the delay line that sits between the second and third write-data capture latches. Software loads the table so that a fast chain, which means high supply and a large count, gets a small delay, and a slow chain gets a large delay.
- A comparison of the count against a programmable threshold picks the delay-line flavour for the delay-locked loop. A short period, which means a high data rate, selects the low-jitter current-mode line. A long period selects the low-power CMOS line.

Both settings are then held. The controller next waits for the loop to report lock, with duty-cycle correction finished. It then latches a measured loop delay and compares it against programmable breakpoints to choose a power-of-two division ratio for the feedback and phase-detector clocks. A done flag marks all results valid, and every result stays frozen until the next recalibration. If lock does not arrive within a programmable cycle budget, a late flag is raised. The data-strobe end-of-burst alignment is not driven by this block.

Top module: `tdc_cal_ctrl`

## Requirements
- R1: After reset, `dly_code` equals parameter `DEF_CODE`, and `fast_path`, `div_log2`, `cal_done` and `lock_late` are all 0. The block waits for a measurement.
- R2: In the default decode variant, the stage count is the index of the lowest 0 bit of `tdc_therm`, counting from bit 0. Bits above that first 0 are ignored. An all-ones word gives `TDC_W`, and an all-zeros word gives 0.
- R3: When `tdc_valid` is high on a clock edge while the block is measuring, `dly_code` takes the table entry `lut_flat[count*CODE_W +: CODE_W]` at that edge. The block then waits for lock.
- R4: At the same edge, `fast_path` becomes 1 (low-jitter line) when the count is below `rate_thr`, and 0 (low-power line) otherwise.
- R5: `tdc_valid` is ignored outside the measuring phase. `dly_code` and `fast_path` change only at a measurement edge.
- R6: When `lock_done` is high on an edge while the block is waiting for lock, `div_log2` takes the number of breakpoints `brk_flat[k*LOOP_W +: LOOP_W]` that are less than or equal to `loop_dly`, and `cal_done` rises at that same edge. The division ratio is 2 to the power `div_log2`.
- R7: While `cal_done` is 1, `lock_done`, `loop_dly` and `tdc_valid` have no effect, and all outputs stay frozen until `recal_req`.
- R8: `recal_req` high on an edge clears `cal_done` and `lock_late` and returns the block to measuring. It takes priority over a `tdc_valid` on the same edge, which is not captured.
- R9: `lock_late` rises at the `LOCK_LIMIT`-th clock edge spent waiting for lock without `lock_done`. It stays set until `recal_req` or reset, and it does not block a later lock.
- R10: `lock_done` is ignored while the block is measuring. It leaves `cal_done` at 0 and leaves `div_log2` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recal_req | input | 1 | Restart calibration |
| tdc_valid | input | 1 | Thermometer word is valid |
| tdc_therm | input | TDC_W | Thermometer word from the converter flip-flops |
| lut_flat | input | (TDC_W+1)*CODE_W | Count-to-delay-step table, entry i at bits i*CODE_W |
| rate_thr | input | CNT_W | Count below which the low-jitter line is chosen |
| lock_done | input | 1 | Lock and duty-cycle correction finished |
| loop_dly | input | LOOP_W | Measured overall loop delay |
| brk_flat | input | NBRK*LOOP_W | Division breakpoints, breakpoint k at bits k*LOOP_W |
| dly_code | output | CODE_W | Fetch delay-line step code |
| fast_path | output | 1 | 1 selects the low-jitter line, 0 the low-power line |
| div_log2 | output | DIV_W | Log2 of the feedback division ratio |
| cal_done | output | 1 | All results valid |
| lock_late | output | 1 | Lock budget exceeded |

## Verification
The bench builds the block with an 8-bit thermometer word, 4-bit step codes, 5-bit loop delays, three breakpoints and a lock budget of 20 cycles. With these values all 256 thermometer words can be applied, including every bubble pattern, and each one gets its own threshold and loop delay. This covers every table entry, both sides of the rate threshold, and every division ratio. The short lock budget puts the late flag within reach, and the bench checks it one edge before and at the expected edge.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
   typedef enum logic [1:0] {
      CAL_MEAS  = 2'd0,
      CAL_LOCKW = 2'd1,
      CAL_DONE  = 2'd2
   } cal_state_e;

   localparam int DEC_FIRST_ZERO = 0;
   localparam int DEC_POPCOUNT   = 1;
endpackage

// File: rtl/tdc_therm_decode.sv
module tdc_therm_decode #(
   parameter int TDC_W    = 16,
   parameter int DEC_MODE = 0,
   localparam int CNT_W   = $clog2(TDC_W + 1)
) (
   input  logic [TDC_W-1:0] therm,
   output logic [CNT_W-1:0] count
);
   generate
      if (DEC_MODE == tdc_cal_pkg::DEC_FIRST_ZERO) begin : g_first_zero
         always_comb begin
            count = CNT_W'(TDC_W);
            for (int i = TDC_W - 1; i >= 0; i--) begin
               if (!therm[i]) count = CNT_W'(i);
            end
         end
      end else begin : g_popcount
         always_comb begin
            count = '0;
            for (int i = 0; i < TDC_W; i++) begin
               count = count + CNT_W'(therm[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tdc_code_map.sv
module tdc_code_map #(
   parameter int TDC_W  = 16,
   parameter int CODE_W = 5,
   localparam int CNT_W = $clog2(TDC_W + 1),
   localparam int LUT_N = TDC_W + 1
) (
   input  logic [CNT_W-1:0]        count,
   input  logic [LUT_N*CODE_W-1:0] lut_flat,
   input  logic [CNT_W-1:0]        rate_thr,
   output logic [CODE_W-1:0]       code,
   output logic                    fast
);
   logic [CODE_W-1:0] entry [LUT_N];

   generate
      for (genvar e = 0; e < LUT_N; e++) begin : g_entry
         assign entry[e] = lut_flat[e*CODE_W +: CODE_W];
      end
   endgenerate

   always_comb begin
      code = entry[0];
      for (int e = 0; e < LUT_N; e++) begin
         if (count == CNT_W'(e)) code = entry[e];
      end
   end

   // Short period (few stages) means high rate: pick the low-jitter line.
   assign fast = (count < rate_thr);
endmodule

// File: rtl/tdc_div_pick.sv
module tdc_div_pick #(
   parameter int LOOP_W = 8,
   parameter int NBRK   = 3,
   localparam int DIV_W = $clog2(NBRK + 1)
) (
   input  logic [LOOP_W-1:0]      loop_dly,
   input  logic [NBRK*LOOP_W-1:0] brk_flat,
   output logic [DIV_W-1:0]       div_log2
);
   logic [NBRK-1:0] meets;

   generate
      for (genvar k = 0; k < NBRK; k++) begin : g_brk
         assign meets[k] = (loop_dly >= brk_flat[k*LOOP_W +: LOOP_W]);
      end
   endgenerate

   always_comb begin
      div_log2 = '0;
      for (int k = 0; k < NBRK; k++) begin
         div_log2 = div_log2 + DIV_W'(meets[k]);
      end
   end
endmodule

// File: rtl/tdc_cal_ctrl.sv
module tdc_cal_ctrl #(
   parameter int TDC_W      = 16,
   parameter int CODE_W     = 5,
   parameter int LOOP_W     = 8,
   parameter int NBRK       = 3,
   parameter int LOCK_LIMIT = 500,
   parameter int DEF_CODE   = 8,
   parameter int DEC_MODE   = 0,
   localparam int CNT_W     = $clog2(TDC_W + 1),
   localparam int LUT_N     = TDC_W + 1,
   localparam int DIV_W     = $clog2(NBRK + 1),
   localparam int LCK_W     = $clog2(LOCK_LIMIT + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    recal_req,
   input  logic                    tdc_valid,
   input  logic [TDC_W-1:0]        tdc_therm,
   input  logic [LUT_N*CODE_W-1:0] lut_flat,
   input  logic [CNT_W-1:0]        rate_thr,
   input  logic                    lock_done,
   input  logic [LOOP_W-1:0]       loop_dly,
   input  logic [NBRK*LOOP_W-1:0]  brk_flat,
   output logic [CODE_W-1:0]       dly_code,
   output logic                    fast_path,
   output logic [DIV_W-1:0]        div_log2,
   output logic                    cal_done,
   output logic                    lock_late
);
   import tdc_cal_pkg::*;

   generate
      if (TDC_W < 2) begin : g_bad_tdc
         $error("TDC_W must be at least 2");
      end
      if (NBRK < 1) begin : g_bad_brk
         $error("NBRK must be at least 1");
      end
      if (LOCK_LIMIT < 2) begin : g_bad_lock
         $error("LOCK_LIMIT must be at least 2");
      end
      if (DEF_CODE < 0 || DEF_CODE >= (1 << CODE_W)) begin : g_bad_def
         $error("DEF_CODE must fit in CODE_W bits");
      end
      if (DEC_MODE != DEC_FIRST_ZERO && DEC_MODE != DEC_POPCOUNT) begin : g_bad_mode
         $error("DEC_MODE must select a known decoder");
      end
   endgenerate

   cal_state_e          state;
   logic [LCK_W-1:0]    wait_cnt;
   logic [CNT_W-1:0]    stage_cnt;
   logic [CODE_W-1:0]   map_code;
   logic                map_fast;
   logic [DIV_W-1:0]    pick_div;

   tdc_therm_decode #(
      .TDC_W   (TDC_W),
      .DEC_MODE(DEC_MODE)
   ) i_decode (
      .therm(tdc_therm),
      .count(stage_cnt)
   );

   tdc_code_map #(
      .TDC_W (TDC_W),
      .CODE_W(CODE_W)
   ) i_map (
      .count   (stage_cnt),
      .lut_flat(lut_flat),
      .rate_thr(rate_thr),
      .code    (map_code),
      .fast    (map_fast)
   );

   tdc_div_pick #(
      .LOOP_W(LOOP_W),
      .NBRK  (NBRK)
   ) i_div (
      .loop_dly(loop_dly),
      .brk_flat(brk_flat),
      .div_log2(pick_div)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CAL_MEAS;
         wait_cnt  <= '0;
         dly_code  <= CODE_W'(DEF_CODE);
         fast_path <= 1'b0;
         div_log2  <= '0;
         cal_done  <= 1'b0;
         lock_late <= 1'b0;
      end else if (recal_req) begin
         state     <= CAL_MEAS;
         wait_cnt  <= '0;
         cal_done  <= 1'b0;
         lock_late <= 1'b0;
      end else begin
         case (state)
            CAL_MEAS: begin
               if (tdc_valid) begin
                  dly_code  <= map_code;
                  fast_path <= map_fast;
                  wait_cnt  <= '0;
                  state     <= CAL_LOCKW;
               end
            end
            CAL_LOCKW: begin
               if (lock_done) begin
                  div_log2 <= pick_div;
                  cal_done <= 1'b1;
                  state    <= CAL_DONE;
               end else begin
                  if (wait_cnt < LCK_W'(LOCK_LIMIT)) wait_cnt <= wait_cnt + 1'b1;
                  if (wait_cnt == LCK_W'(LOCK_LIMIT - 1)) lock_late <= 1'b1;
               end
            end
            default: begin
               state <= CAL_DONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/tdc_cal_ctrl_chk.sv
module tdc_cal_ctrl_chk #(
   parameter int CODE_W = 5,
   parameter int DIV_W  = 2,
   parameter int NBRK   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              recal_req,
   input logic              tdc_valid,
   input logic              lock_done,
   input logic [CODE_W-1:0] dly_code,
   input logic              fast_path,
   input logic [DIV_W-1:0]  div_log2,
   input logic              cal_done,
   input logic              lock_late
);
   AST_CODE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) !$past(tdc_valid) |-> ($stable(dly_code) && $stable(fast_path))); // R5
   AST_DONE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(cal_done) |-> $past(lock_done)); // R6
   AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(div_log2) <= NBRK); // R6
   AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (cal_done && $past(cal_done)) |-> ($stable(div_log2) && $stable(dly_code) && $stable(fast_path))); // R7
   AST_RECAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $past(recal_req) |-> (!cal_done && !lock_late)); // R8
   AST_LATE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock_late) |-> !cal_done); // R9
endmodule

bind tdc_cal_ctrl tdc_cal_ctrl_chk #(
   .CODE_W(CODE_W),
   .DIV_W (DIV_W),
   .NBRK  (NBRK)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .recal_req(recal_req),
   .tdc_valid(tdc_valid),
   .lock_done(lock_done),
   .dly_code (dly_code),
   .fast_path(fast_path),
   .div_log2 (div_log2),
   .cal_done (cal_done),
   .lock_late(lock_late)
);

// File: tb/test_tdc_cal_ctrl.sv
`timescale 1ns/1ps
module test_tdc_cal_ctrl;
   localparam int TW = 8;
   localparam int CW = 4;
   localparam int LW = 5;
   localparam int NB = 3;
   localparam int LL = 20;
   localparam int DC = 3;
   localparam int NW = $clog2(TW + 1);
   localparam int DW = $clog2(NB + 1);

   logic               clk = 0;
   logic               rst_n = 0;
   logic               recal_req = 0;
   logic               tdc_valid = 0;
   logic [TW-1:0]      tdc_therm = '0;
   logic [(TW+1)*CW-1:0] lut_flat;
   logic [NW-1:0]      rate_thr = '0;
   logic               lock_done = 0;
   logic [LW-1:0]      loop_dly = '0;
   logic [NB*LW-1:0]   brk_flat;
   logic [CW-1:0]      dly_code;
   logic               fast_path;
   logic [DW-1:0]      div_log2;
   logic               cal_done;
   logic               lock_late;

   int vecs = 0;
   int errs = 0;

   always #2.5 clk = ~clk;

   tdc_cal_ctrl #(
      .TDC_W(TW), .CODE_W(CW), .LOOP_W(LW), .NBRK(NB),
      .LOCK_LIMIT(LL), .DEF_CODE(DC), .DEC_MODE(0)
   ) i_tdc_cal_ctrl (
      .clk(clk), .rst_n(rst_n), .recal_req(recal_req), .tdc_valid(tdc_valid),
      .tdc_therm(tdc_therm), .lut_flat(lut_flat), .rate_thr(rate_thr),
      .lock_done(lock_done), .loop_dly(loop_dly), .brk_flat(brk_flat),
      .dly_code(dly_code), .fast_path(fast_path), .div_log2(div_log2),
      .cal_done(cal_done), .lock_late(lock_late)
   );

   function automatic int first_zero(input logic [TW-1:0] t);
      for (int i = 0; i < TW; i++) if (!t[i]) return i;
      return TW;
   endfunction

   function automatic int exp_div(input int ld);
      return int'(ld >= 4) + int'(ld >= 10) + int'(ld >= 20);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_recal();
      recal_req = 1;
      tick();
      recal_req = 0;
   endtask

   task automatic measure(input logic [TW-1:0] t, input int thr);
      tdc_therm = t;
      rate_thr  = NW'(thr);
      tdc_valid = 1;
      tick();
      tdc_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      // Table entry i = TW - i: more stages (fast chain) gives less delay.
      for (int i = 0; i <= TW; i++) lut_flat[i*CW +: CW] = CW'(TW - i);
      brk_flat = {LW'(20), LW'(10), LW'(4)};

      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      chk("R1 dly_code", int'(dly_code), DC);
      chk("R1 fast_path", int'(fast_path), 0);
      chk("R1 div_log2", int'(div_log2), 0);
      chk("R1 cal_done", int'(cal_done), 0);
      chk("R1 lock_late", int'(lock_late), 0);

      // R10: lock_done while measuring is ignored
      loop_dly = LW'(31);
      lock_done = 1;
      tick();
      lock_done = 0;
      chk("R10 cal_done", int'(cal_done), 0);
      chk("R10 div_log2", int'(div_log2), 0);

      // Sweep of every thermometer word
      for (int c = 0; c < (1 << TW); c++) begin
         logic [TW-1:0] t;
         int cnt;
         int thr;
         int ld;
         t   = TW'(c);
         cnt = first_zero(t);
         thr = c % (TW + 1);
         ld  = c % 32;
         do_recal();
         chk("R8 cal_done cleared", int'(cal_done), 0);
         measure(t, thr);
         chk("R2/R3 dly_code", int'(dly_code), TW - cnt);
         chk("R4 fast_path", int'(fast_path), int'(cnt < thr));
         chk("R6 cal_done before lock", int'(cal_done), 0);
         // R5: a second word while waiting for lock is ignored
         tdc_therm = ~t;
         rate_thr  = NW'(TW);
         tdc_valid = 1;
         tick();
         tdc_valid = 0;
         chk("R5 dly_code held", int'(dly_code), TW - cnt);
         chk("R5 fast_path held", int'(fast_path), int'(cnt < thr));
         loop_dly  = LW'(ld);
         lock_done = 1;
         tick();
         lock_done = 0;
         chk("R6 div_log2", int'(div_log2), exp_div(ld));
         chk("R6 cal_done", int'(cal_done), 1);
         // R7: further lock, loop delay and words have no effect
         loop_dly  = LW'(31 - ld);
         lock_done = 1;
         tdc_valid = 1;
         tdc_therm = ~t;
         tick();
         lock_done = 0;
         tdc_valid = 0;
         chk("R7 div_log2 frozen", int'(div_log2), exp_div(ld));
         chk("R7 dly_code frozen", int'(dly_code), TW - cnt);
         chk("R7 cal_done held", int'(cal_done), 1);
      end

      // R9: lock budget
      do_recal();
      measure(8'b0000_0111, 2);
      for (int k = 0; k < LL - 1; k++) tick();
      chk("R9 lock_late one edge early", int'(lock_late), 0);
      tick();
      chk("R9 lock_late at limit", int'(lock_late), 1);
      loop_dly  = LW'(12);
      lock_done = 1;
      tick();
      lock_done = 0;
      chk("R9 late lock still completes", int'(cal_done), 1);
      chk("R9 late lock div", int'(div_log2), 2);
      chk("R9 lock_late sticky", int'(lock_late), 1);

      // R8: recal clears flags and beats a same-edge tdc_valid
      tdc_therm = 8'hFF;
      rate_thr  = NW'(0);
      tdc_valid = 1;
      recal_req = 1;
      tick();
      recal_req = 0;
      tdc_valid = 0;
      chk("R8 cal_done", int'(cal_done), 0);
      chk("R8 lock_late", int'(lock_late), 0);
      chk("R8 no capture with recal", int'(dly_code), TW - 3);
      measure(8'hFF, 0);
      chk("R2 all ones saturates", int'(dly_code), 0);
      do_recal();
      measure(8'h00, 1);
      chk("R2 all zeros", int'(dly_code), TW);
      chk("R4 fast at zero count", int'(fast_path), 1);

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule